// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register File

This block is the host-facing register layer of a two-channel asynchronous serial controller. Each channel shows the host two byte-wide ports, a control port and a data port. Most registers are reached indirectly: the host first writes a register number into control register 0, and its next control-port access goes to that register. After any access to a register other than 0, the pointer falls back to 0. The same write to register 0 also carries a three-bit command field. One command code extends the pointer into the upper half of the sixteen-entry space. Two other codes produce one-cycle strobes for the interrupt logic.

The block stores the write registers and applies their reset defaults, both at hardware reset and on a per-channel software reset requested through the shared master-control register. It assembles the readable status, holds a received byte delivered from outside, and presents each transmit byte together with a strobe. Serialization, baud generation and modem lines belong to neighbouring blocks, which read the stored configuration through a flat register bus.

Top module: `sccRegFile`

## Requirements
- R1: Host address bit 2 selects the channel (0 = channel B, 1 = channel A) and address bit 0 selects the port (0 = control, 1 = data). Addresses with bit 1 set are ignored on write and read as 0x00.
- R2: On a control-port write while the channel's pointer is 0, data bits 2:0 load the pointer. The next control-port access reaches that register. Any control-port access to a register other than 0 returns the pointer to 0.
- R3: When data bits 5:3 of that write equal 001, the pointer becomes 8 plus bits 2:0.
- R4: When data bits 5:3 of that write equal 101, `clrTxIntPulse` is high for that channel for exactly the cycle after the write. The code 111 does the same on `clrIusPulse`. Bit 0 of each strobe is channel B and bit 1 is channel A.
- R5: After hardware reset, write registers 4, 9, 11, 14 and 15 hold 0x04, 0xC0, 0x08, 0x30 and 0xF8, and all other write registers hold 0. Status register 0 reads 0x44 (bit 2 transmit empty, bit 6 underrun), and register 1 reads 0x07. `wrRegFlat[(c*16+r)*8 +: 8]` is write register r of channel c.
- R6: Writing register 9 with bits 7:6 = 01 resets channel B, 10 resets channel A, and 11 resets both. A reset channel's write registers other than 9, its receive buffer and its status return to their hardware-reset values, and its pointer returns to 0.
- R7: Register 9 is shared. A write through either channel stores the value in both channel copies.
- R8: A pulse on `rxValid` while the channel's register 3 bit 0 is set stores `rxByte` and sets status bit 0. When that bit is clear, the pulse is ignored. Data-port reads and register 8 return the buffer, and a data-port read clears status bit 0.
- R9: A data-port write, or a control-port write to register 8, while register 5 bit 3 is set stores the byte as register 8. It then drives `txStrobe` for the next cycle with the byte on `txByte`, and clears status bit 2 until `txTaken`. When register 5 bit 3 is clear, the write is ignored.
- R10: `rxEnable` follows register 3 bit 0 and `txEnable` follows register 5 bit 3, per channel.
- R11: Read registers 2, 12, 13 and 15 return the matching write register. Read registers 3 to 7, 9 to 11 and 14 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Host offset |
| busWr | input | 1 | Host write strobe |
| busRd | input | 1 | Host read strobe |
| busWdata | input | 8 | Host write data |
| busRdata | output | 8 | Host read data (combinational) |
| rxValid | input | 2 | Received byte valid, per channel |
| rxByte | input | 16 | Received bytes, channel c at [c*8 +: 8] |
| txTaken | input | 2 | Transmit byte consumed, per channel |
| txStrobe | output | 2 | New transmit byte, per channel |
| txByte | output | 16 | Transmit bytes, channel c at [c*8 +: 8] |
| rxEnable | output | 2 | Receiver enabled, per channel |
| txEnable | output | 2 | Transmitter enabled, per channel |
| clrTxIntPulse | output | 2 | Clear-transmit-interrupt command strobe |
| clrIusPulse | output | 2 | Clear-highest-in-service command strobe |
| wrRegFlat | output | 256 | All write registers of both channels |

## Verification
The bench uses the package defaults: two channels and sixteen byte-wide registers. A four-bit pointer can therefore reach both the lower and the upper half of the register space, and the point-high command is the only way into the upper half. Because both channels are present, the swapped channel offsets, the shared master register and each of the three software-reset selections can be observed across channels. Random traffic mixes pointer loads, command writes, data transfers and injected receive bytes against a bench model.

// File: rtl/sccRegPkg.sv
package sccRegPkg;
  localparam int CH_NUM = 2;
  localparam int CH_W = $clog2(CH_NUM);
  localparam int BYTE_W = 8;
  localparam int REG_NUM = 16;
  localparam int PTR_W = $clog2(REG_NUM);
  localparam int ADDR_W = 3;
  localparam int FLAT_W = CH_NUM * REG_NUM * BYTE_W;

  localparam int IDX_IVEC = 2;
  localparam int IDX_RXCFG = 3;
  localparam int IDX_TXCFG = 5;
  localparam int IDX_BUF = 8;
  localparam int IDX_MASTER = 9;

  localparam logic [2:0] CMD_POINT_HI = 3'b001;
  localparam logic [2:0] CMD_CLR_TX = 3'b101;
  localparam logic [2:0] CMD_CLR_IUS = 3'b111;

  typedef struct packed {
    logic [CH_W-1:0] ch;
    logic regWr;
    logic dataWr;
    logic dataRd;
    logic [PTR_W-1:0] idx;
    logic [BYTE_W-1:0] wdata;
    logic [CH_NUM-1:0] chReset;
    logic rdValid;
    logic [PTR_W-1:0] rdIdx;
  } strobeT;

  function automatic logic [BYTE_W-1:0] wrDefault(input int r);
    case (r)
      4: return 8'h04;
      9: return 8'hC0;
      11: return 8'h08;
      14: return 8'h30;
      15: return 8'hF8;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/sccRegCtrl.sv
module sccRegCtrl import sccRegPkg::*; (
  input  logic clk,
  input  logic rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic busWr,
  input  logic busRd,
  input  logic [BYTE_W-1:0] busWdata,
  output strobeT stb,
  output logic [CH_NUM-1:0] clrTxIntPulse,
  output logic [CH_NUM-1:0] clrIusPulse
);
  logic [PTR_W-1:0] ptr [CH_NUM];
  logic [CH_W-1:0] portCh;
  logic portOk, isData, ctrlWr, ctrlRd;
  logic [PTR_W-1:0] curPtr;
  logic [2:0] cmd;

  assign portCh = busAddr[ADDR_W-1 -: CH_W];
  assign portOk = (busAddr[1] == 1'b0);
  assign isData = busAddr[0];
  assign curPtr = ptr[portCh];
  assign cmd = busWdata[5:3];
  assign ctrlWr = busWr && portOk && !isData;
  assign ctrlRd = busRd && !busWr && portOk && !isData;

  always_comb begin
    stb = '0;
    stb.ch = portCh;
    stb.wdata = busWdata;
    stb.rdValid = portOk;
    stb.rdIdx = isData ? PTR_W'(IDX_BUF) : curPtr;
    if (busWr && portOk) begin
      if (isData || curPtr == PTR_W'(IDX_BUF)) begin
        stb.dataWr = 1'b1;
      end else begin
        stb.regWr = 1'b1;
        stb.idx = curPtr;
        if (curPtr == PTR_W'(IDX_MASTER)) begin
          stb.chReset = {busWdata[7], busWdata[6]};
        end
      end
    end
    if (busRd && !busWr && portOk && isData) stb.dataRd = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < CH_NUM; c++) ptr[c] <= '0;
      clrTxIntPulse <= '0;
      clrIusPulse <= '0;
    end else begin
      clrTxIntPulse <= '0;
      clrIusPulse <= '0;
      for (int c = 0; c < CH_NUM; c++) begin
        if (stb.chReset[c]) ptr[c] <= '0;
      end
      if (ctrlWr) begin
        if (curPtr == '0) begin
          ptr[portCh] <= {cmd == CMD_POINT_HI, busWdata[2:0]};
          if (cmd == CMD_CLR_TX) clrTxIntPulse[portCh] <= 1'b1;
          if (cmd == CMD_CLR_IUS) clrIusPulse[portCh] <= 1'b1;
        end else begin
          ptr[portCh] <= '0;
        end
      end else if (ctrlRd && curPtr != '0) begin
        ptr[portCh] <= '0;
      end
    end
  end
endmodule

// File: rtl/sccRegData.sv
module sccRegData import sccRegPkg::*; (
  input  logic clk,
  input  logic rstN,
  input  strobeT stb,
  input  logic [CH_NUM-1:0] rxValid,
  input  logic [CH_NUM*BYTE_W-1:0] rxByte,
  input  logic [CH_NUM-1:0] txTaken,
  output logic [BYTE_W-1:0] busRdata,
  output logic [CH_NUM-1:0] txStrobe,
  output logic [CH_NUM*BYTE_W-1:0] txByte,
  output logic [CH_NUM-1:0] rxEnable,
  output logic [CH_NUM-1:0] txEnable,
  output logic [FLAT_W-1:0] wrRegFlat
);
  logic [BYTE_W-1:0] wrReg [CH_NUM][REG_NUM];
  logic [BYTE_W-1:0] rxBuf [CH_NUM];
  logic [CH_NUM-1:0] rxAvail, txEmpty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < CH_NUM; c++) begin
        for (int r = 0; r < REG_NUM; r++) wrReg[c][r] <= wrDefault(r);
        rxBuf[c] <= '0;
      end
      rxAvail <= '0;
      txEmpty <= '1;
      txStrobe <= '0;
    end else begin
      txStrobe <= '0;
      for (int c = 0; c < CH_NUM; c++) begin
        if (stb.chReset[c]) begin
          for (int r = 0; r < REG_NUM; r++) begin
            if (r != IDX_MASTER) wrReg[c][r] <= wrDefault(r);
          end
          rxBuf[c] <= '0;
          rxAvail[c] <= 1'b0;
          txEmpty[c] <= 1'b1;
        end else begin
          if (txTaken[c]) txEmpty[c] <= 1'b1;
          if (stb.dataRd && stb.ch == CH_W'(c)) rxAvail[c] <= 1'b0;
          if (rxValid[c] && wrReg[c][IDX_RXCFG][0]) begin
            rxBuf[c] <= rxByte[c*BYTE_W +: BYTE_W];
            rxAvail[c] <= 1'b1;
          end
          if (stb.dataWr && stb.ch == CH_W'(c) && wrReg[c][IDX_TXCFG][3]) begin
            wrReg[c][IDX_BUF] <= stb.wdata;
            txEmpty[c] <= 1'b0;
            txStrobe[c] <= 1'b1;
          end
          if (stb.regWr && stb.ch == CH_W'(c) && stb.idx != PTR_W'(IDX_MASTER)) begin
            wrReg[c][stb.idx] <= stb.wdata;
          end
        end
        if (stb.regWr && stb.idx == PTR_W'(IDX_MASTER)) wrReg[c][IDX_MASTER] <= stb.wdata;
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (stb.rdValid) begin
      case (stb.rdIdx)
        4'd0: busRdata = {1'b0, 1'b1, 3'b000, txEmpty[stb.ch], 1'b0, rxAvail[stb.ch]};
        4'd1: busRdata = 8'h07;
        4'd2, 4'd12, 4'd13, 4'd15: busRdata = wrReg[stb.ch][stb.rdIdx];
        4'd8: busRdata = rxBuf[stb.ch];
        default: busRdata = '0;
      endcase
    end
  end

  always_comb begin
    for (int c = 0; c < CH_NUM; c++) begin
      rxEnable[c] = wrReg[c][IDX_RXCFG][0];
      txEnable[c] = wrReg[c][IDX_TXCFG][3];
      txByte[c*BYTE_W +: BYTE_W] = wrReg[c][IDX_BUF];
      for (int r = 0; r < REG_NUM; r++) begin
        wrRegFlat[(c*REG_NUM+r)*BYTE_W +: BYTE_W] = wrReg[c][r];
      end
    end
  end
endmodule

// File: rtl/sccRegFile.sv
module sccRegFile import sccRegPkg::*; (
  input  logic clk,
  input  logic rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic busWr,
  input  logic busRd,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  input  logic [CH_NUM-1:0] rxValid,
  input  logic [CH_NUM*BYTE_W-1:0] rxByte,
  input  logic [CH_NUM-1:0] txTaken,
  output logic [CH_NUM-1:0] txStrobe,
  output logic [CH_NUM*BYTE_W-1:0] txByte,
  output logic [CH_NUM-1:0] rxEnable,
  output logic [CH_NUM-1:0] txEnable,
  output logic [CH_NUM-1:0] clrTxIntPulse,
  output logic [CH_NUM-1:0] clrIusPulse,
  output logic [FLAT_W-1:0] wrRegFlat
);
  strobeT stb;

  sccRegCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .stb(stb), .clrTxIntPulse(clrTxIntPulse),
    .clrIusPulse(clrIusPulse)
  );

  sccRegData u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .rxValid(rxValid), .rxByte(rxByte),
    .txTaken(txTaken), .busRdata(busRdata), .txStrobe(txStrobe), .txByte(txByte),
    .rxEnable(rxEnable), .txEnable(txEnable), .wrRegFlat(wrRegFlat)
  );
endmodule

// File: rtl/sccRegChk.sv
module sccRegChk import sccRegPkg::*; (
  input logic clk,
  input logic rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic busWr,
  input logic busRd,
  input logic [BYTE_W-1:0] busWdata,
  input logic [BYTE_W-1:0] busRdata,
  input logic [CH_NUM-1:0] txStrobe,
  input logic [CH_NUM-1:0] txEnable,
  input logic [CH_NUM-1:0] clrTxIntPulse,
  input logic [CH_NUM-1:0] clrIusPulse
);
  // R1
  bad_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr[1]) |-> busRdata == '0);
  // R4
  clr_tx_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|clrTxIntPulse) |-> ($past(busWr) && $past(busWdata[5:3]) == CMD_CLR_TX
                          && $past(busAddr[1:0]) == 2'b00));
  // R4
  clr_ius_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|clrIusPulse) |-> ($past(busWr) && $past(busWdata[5:3]) == CMD_CLR_IUS
                        && $past(busAddr[1:0]) == 2'b00));
  // R4
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({clrTxIntPulse, clrIusPulse}));
  // R9
  tx_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|txStrobe) |-> $past(busWr));
  // R9
  tx_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(txStrobe & ~$past(txEnable))) == 1'b0);
endmodule

bind sccRegFile sccRegChk u_sccRegChk (.*);

// File: tb/sccRegFile_bench.sv
`timescale 1ns/1ps
module sccRegFile_bench;
  import sccRegPkg::*;
  logic clk = 0, rstN = 0;
  logic [2:0] busAddr = 0;
  logic busWr = 0, busRd = 0;
  logic [7:0] busWdata = 0, busRdata;
  logic [1:0] rxValid = 0, txTaken = 0;
  logic [15:0] rxByte = 0;
  logic [1:0] txStrobe, rxEnable, txEnable, clrTxIntPulse, clrIusPulse;
  logic [15:0] txByte;
  logic [255:0] wrRegFlat;
  logic [1:0] seenTx, seenClrTx, seenIus;
  int nChk = 0, nErr = 0;
  bit done = 0;
  logic [7:0] wrM [2][16];
  logic [7:0] rxBufM [2];
  logic rxAvM [2], txEmM [2];

  always #4 clk = ~clk;

  sccRegFile u_sccRegFile (.*);

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] defVal(input int r);
    case (r)
      4: return 8'h04; 9: return 8'hC0; 11: return 8'h08;
      14: return 8'h30; 15: return 8'hF8; default: return 8'h00;
    endcase
  endfunction

  task automatic modelChReset(input int c);
    for (int r = 0; r < 16; r++) if (r != 9) wrM[c][r] = defVal(r);
    rxBufM[c] = 0; rxAvM[c] = 0; txEmM[c] = 1;
  endtask

  function automatic logic [7:0] rrExp(input int c, input int idx);
    case (idx)
      0: return {6'b010000, txEmM[c], 1'b0} | {7'b0, rxAvM[c]} | 8'h04 & {5'b0, txEmM[c], 2'b0};
      1: return 8'h07;
      2, 12, 13, 15: return wrM[c][idx];
      8: return rxBufM[c];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] st0(input int c);
    return 8'h40 | (txEmM[c] ? 8'h04 : 8'h00) | (rxAvM[c] ? 8'h01 : 8'h00);
  endfunction

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWr = 1;
    @(posedge clk); #1;
    seenTx = txStrobe; seenClrTx = clrTxIntPulse; seenIus = clrIusPulse;
    @(negedge clk); busWr = 0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); busAddr = a; busRd = 1; #1; d = busRdata;
    @(posedge clk);
    @(negedge clk); busRd = 0;
  endtask

  function automatic logic [2:0] ctl(input int c); return {c[0], 2'b00}; endfunction
  function automatic logic [2:0] dat(input int c); return {c[0], 2'b01}; endfunction

  task automatic setPtr(input int c, input int idx);
    logic [7:0] b;
    b = (idx >= 8) ? (8'h08 | 8'(idx & 7)) : 8'(idx);
    busWrite(ctl(c), b);
    wrM[c][0] = b;
  endtask

  task automatic dataWrite(input int c, input logic [7:0] v);
    busWrite(dat(c), v);
    if (wrM[c][5][3]) begin wrM[c][8] = v; txEmM[c] = 0; end
  endtask

  task automatic regWrite(input int c, input int idx, input logic [7:0] v);
    setPtr(c, idx);
    if (idx == 8) begin
      busWrite(ctl(c), v);
      if (wrM[c][5][3]) begin wrM[c][8] = v; txEmM[c] = 0; end
    end else begin
      busWrite(ctl(c), v);
      if (idx == 9) begin
        if (v[6]) modelChReset(0);
        if (v[7]) modelChReset(1);
        wrM[0][9] = v; wrM[1][9] = v;
      end else wrM[c][idx] = v;
    end
  endtask

  task automatic regRead(input int c, input int idx, output logic [7:0] v);
    if (idx != 0) setPtr(c, idx);
    busRead(ctl(c), v);
  endtask

  task automatic rxInject(input int c, input logic [7:0] b);
    @(negedge clk); rxByte[c*8 +: 8] = b; rxValid[c] = 1;
    @(negedge clk); rxValid = 0;
    if (wrM[c][3][0]) begin rxBufM[c] = b; rxAvM[c] = 1; end
  endtask

  task automatic txTake(input int c);
    @(negedge clk); txTaken[c] = 1;
    @(negedge clk); txTaken = 0;
    txEmM[c] = 1;
  endtask

  task automatic checkFlat(input string tag);
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < 16; r++)
        check(tag, wrRegFlat[(c*16+r)*8 +: 8], wrM[c][r]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++; nErr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nChk, nErr);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1357));
    for (int c = 0; c < 2; c++) begin
      for (int r = 0; r < 16; r++) wrM[c][r] = defVal(r);
      rxBufM[c] = 0; rxAvM[c] = 0; txEmM[c] = 1;
    end
    repeat (3) @(negedge clk);
    rstN = 1;
    // R5 reset state
    checkFlat("R5 reset defaults");
    for (int c = 0; c < 2; c++) begin
      regRead(c, 0, v); check("R5 RR0 after reset", v, 8'h44);
      regRead(c, 1, v); check("R5 RR1 after reset", v, 8'h07);
    end
    check("R10 rxEnable reset", {6'b0, rxEnable}, 8'h00);
    // R1 channel offsets swapped and unused offsets
    regWrite(1, 12, 8'h5A);
    check("R1 A at offset 4", wrRegFlat[(16+12)*8 +: 8], 8'h5A);
    check("R1 B untouched", wrRegFlat[12*8 +: 8], 8'h00);
    busWrite(3'd2, 8'h0C); busWrite(3'd6, 8'h0D);
    checkFlat("R1 ignored offset write");
    busRead(3'd3, v); check("R1 offset 3 reads 0", v, 8'h00);
    busRead(3'd7, v); check("R1 offset 7 reads 0", v, 8'h00);
    // R3 point high, R2 pointer return
    regRead(1, 12, v); check("R3 point high reaches RR12", v, 8'h5A);
    busRead(ctl(1), v); check("R2 pointer back to 0", v, 8'h44);
    regWrite(0, 2, 8'h33);
    regRead(0, 2, v); check("R11 RR2 mirrors WR2", v, 8'h33);
    regRead(0, 3, v); check("R11 RR3 reads 0", v, 8'h00);
    // R4 commands
    busWrite(ctl(1), 8'h28); wrM[1][0] = 8'h28;
    check("R4 clear tx on A", {6'b0, seenClrTx}, 8'h02);
    check("R4 no ius on A", {6'b0, seenIus}, 8'h00);
    busWrite(ctl(0), 8'h38); wrM[0][0] = 8'h38;
    check("R4 clear ius on B", {6'b0, seenIus}, 8'h01);
    busRead(ctl(0), v); check("R2 command keeps pointer 0", v, 8'h44);
    // R8 receive
    rxInject(0, 8'h99);
    busRead(ctl(0), v); check("R8 rx ignored while disabled", v, 8'h44);
    regWrite(0, 3, 8'h01);
    check("R10 rxEnable B", {6'b0, rxEnable}, 8'h01);
    rxInject(0, 8'hA5);
    busRead(ctl(0), v); check("R8 rx available", v, 8'h45);
    regRead(0, 8, v); check("R8 RR8 buffer", v, 8'hA5);
    busRead(dat(0), v); check("R8 data read", v, 8'hA5); rxAvM[0] = 0;
    busRead(ctl(0), v); check("R8 read clears avail", v, 8'h44);
    // R9 transmit
    dataWrite(0, 8'h11);
    check("R9 tx ignored while disabled", {6'b0, seenTx}, 8'h00);
    regWrite(0, 5, 8'h08);
    check("R10 txEnable B", {6'b0, txEnable}, 8'h01);
    dataWrite(0, 8'h3C);
    check("R9 strobe B", {6'b0, seenTx}, 8'h01);
    check("R9 tx byte", txByte[7:0], 8'h3C);
    busRead(ctl(0), v); check("R9 tx empty clear", v, 8'h40);
    txTake(0);
    busRead(ctl(0), v); check("R9 tx taken", v, 8'h44);
    regWrite(1, 5, 8'h08);
    regWrite(1, 8, 8'h77);
    check("R9 WR8 control write strobes A", {6'b0, seenTx}, 8'h02);
    check("R9 tx byte A", txByte[15:8], 8'h77);
    txTake(1);
    // R7 shared master register
    regWrite(1, 9, 8'h05);
    check("R7 WR9 copy B", wrRegFlat[9*8 +: 8], 8'h05);
    check("R7 WR9 copy A", wrRegFlat[(16+9)*8 +: 8], 8'h05);
    // R6 channel resets
    regWrite(0, 12, 8'h11);
    regWrite(1, 9, 8'h40);
    check("R6 B reset WR12", wrRegFlat[12*8 +: 8], 8'h00);
    check("R6 A kept WR12", wrRegFlat[(16+12)*8 +: 8], 8'h5A);
    check("R6 B reset rxEnable", {6'b0, rxEnable}, 8'h00);
    regWrite(0, 9, 8'h80);
    check("R6 A reset WR12", wrRegFlat[(16+12)*8 +: 8], 8'h00);
    regWrite(0, 13, 8'h21); regWrite(1, 13, 8'h22);
    regWrite(0, 9, 8'hC0);
    checkFlat("R6 both reset");
    // random mix against model
    for (int i = 0; i < 400; i++) begin
      int c, op, idx;
      c = $urandom_range(1, 0);
      op = $urandom_range(6, 0);
      case (op)
        0: begin
          idx = $urandom_range(15, 1);
          v = $urandom;
          if (idx == 9 && $urandom_range(3, 0) != 0) v[7:6] = 2'b00;
          if (idx == 3) v[0] = $urandom_range(3, 0) != 0;
          if (idx == 5) v[3] = $urandom_range(3, 0) != 0;
          regWrite(c, idx, v);
        end
        1: begin
          idx = $urandom_range(15, 0);
          regRead(c, idx, v);
          check("R11 random read", v, idx == 0 ? st0(c) : rrExp(c, idx));
        end
        2: begin
          logic [1:0] expTx;
          v = $urandom;
          expTx = wrM[c][5][3] ? 2'(1 << c) : 2'b00;
          dataWrite(c, v);
          check("R9 random strobe", {6'b0, seenTx}, {6'b0, expTx});
        end
        3: begin
          busRead(dat(c), v);
          check("R8 random data read", v, rxBufM[c]);
          rxAvM[c] = 0;
        end
        4: rxInject(c, 8'($urandom));
        5: txTake(c);
        default: begin
          logic [2:0] cm;
          cm = ($urandom_range(1, 0) == 0) ? 3'b101 : 3'b111;
          busWrite(ctl(c), {2'b00, cm, 3'b000}); wrM[c][0] = {2'b00, cm, 3'b000};
          check("R4 random clear tx", {6'b0, seenClrTx}, cm == 3'b101 ? 8'(1 << c) : 8'h00);
          check("R4 random clear ius", {6'b0, seenIus}, cm == 3'b111 ? 8'(1 << c) : 8'h00);
        end
      endcase
    end
    for (int c = 0; c < 2; c++) begin
      busRead(ctl(c), v); check("R8 final status", v, st0(c));
    end
    checkFlat("R2 final registers");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChk, nErr);
    $finish;
  end
endmodule